// File: doc/BRIEF.md
# Channel Command and Service-Acknowledge Controller

This block is the host-facing register front end of a four-channel communications controller. A channel-select register steers every per-channel register access to one channel, and all channels share the same offsets. A command register accepts an 8-bit word whose upper nibble is a one-hot command type and whose lower nibble carries the command's argument. It hands the word to an internal executor over a valid/accept handshake and clears itself once the executor takes it. Software polls the register for zero before it issues the next command.

A hardware service-acknowledge input lets the device load the channel select by itself with the number of the channel that asked for service. The host ends that context by writing any value to a write-only end-of-service location. The channel select the host held before the context then comes back. Only the upper channels (2 and 3 by default) take commands. Command writes aimed at the lower channels are dropped without a trace. Malformed command words and stray end-of-service writes raise one-cycle error pulses.

Top module: `chan_cmd_ctrl`

## Requirements
- R1: After reset, chan_sel is 0, svc_active is 0, cmd_valid is 0, cmd_type and cmd_param are 0, and both error pulses are low.
- R2: A host write to the select offset (address 0) loads chan_sel from wdata[1:0] on the next clock. A read of address 0 returns the select value in bits [1:0] with zeros above.
- R3: A write to the command offset (address 1) while channel 2 or 3 is selected, with exactly one bit set in wdata[7:4] and no command pending, raises cmd_valid on the next clock. The same clock puts wdata[7:4] on cmd_type, wdata[3:0] on cmd_param and the selected channel on cmd_chan.
- R4: cmd_valid and the command outputs stay unchanged until cmd_accept is high in a cycle where cmd_valid is high. In the next cycle cmd_valid is low and the command register reads back 0x00.
- R5: A command write while channel 0 or 1 is selected does nothing. It forwards no command, raises no error, and the register reads back 0x00.
- R6: A command write to channel 2 or 3 with two or more type bits set forwards nothing and pulses err_cmd high for exactly one cycle. A write with no type bit set forwards nothing and raises no error.
- R7: A read of the status offset (address 3) returns bit 1 = command busy (write to accept) and bit 0 = service context active. A legal command write made while busy is dropped.
- R8: svc_ack high while no context is active loads chan_sel with svc_chan and sets svc_active on the next clock. svc_ack while a context is active has no effect.
- R9: A write of any data to the end-of-service offset (address 2) during a context clears svc_active and restores the chan_sel value held just before entry.
- R10: A write to address 2 outside a context changes no state and pulses err_eos high for one cycle.
- R11: Address 2 reads as 0x00. Address 1 reads the pending command word only while the pending command's channel is selected, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Host register offset |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Read data, combinational, zero when bus_rd is low |
| svc_ack | input | 1 | Hardware service-acknowledge |
| svc_chan | input | 2 | Channel that requested service |
| cmd_valid | output | 1 | Command offered to the executor |
| cmd_accept | input | 1 | Executor takes the command |
| cmd_chan | output | 2 | Channel of the offered command |
| cmd_type | output | 4 | One-hot command type |
| cmd_param | output | 4 | Command argument |
| chan_sel | output | 2 | Current channel select |
| svc_active | output | 1 | Service-acknowledge context in force |
| err_cmd | output | 1 | One-cycle pulse for a multi-type command word |
| err_eos | output | 1 | One-cycle pulse for a stray end-of-service write |

## Verification
Every piece of state in this block can be seen at the ports one clock after the event that sets it. A wrong select or a lost saved select shows on chan_sel in the cycle after entry to or exit from a context. A stuck or stale command register shows on cmd_valid, cmd_type and the address-1 readback in the cycle after a write or an accept. The bench runs a cycle-by-cycle model beside the block, so any divergence is reported within one clock of the operation that caused it.

// File: rtl/chcmd_pkg.sv
package chcmd_pkg;

   typedef struct packed {
      logic csel;
      logic cmd;
      logic eos;
   } wr_dec_t;

   function automatic logic single_bit(input logic [7:0] v);
      return $countones(v) == 1;
   endfunction

endpackage

// File: rtl/chcmd_chsel.sv
module chcmd_chsel #(
   parameter int CH_W    = 2,
   parameter bit RESTORE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_csel,
   input  logic            wr_eos,
   input  logic [CH_W-1:0] wdata_ch,
   input  logic            svc_ack,
   input  logic [CH_W-1:0] svc_chan,
   output logic [CH_W-1:0] chan_sel,
   output logic            svc_active,
   output logic            err_eos
);

   logic [CH_W-1:0] saved_q;
   logic [CH_W-1:0] exit_sel;

   generate
      if (RESTORE) begin : g_restore
         assign exit_sel = saved_q;
      end else begin : g_keep
         assign exit_sel = chan_sel;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_sel   <= '0;
         saved_q    <= '0;
         svc_active <= 1'b0;
         err_eos    <= 1'b0;
      end else begin
         err_eos <= 1'b0;
         if (svc_ack && !svc_active) begin
            saved_q    <= chan_sel;
            chan_sel   <= svc_chan;
            svc_active <= 1'b1;
         end else if (wr_eos) begin
            if (svc_active) begin
               svc_active <= 1'b0;
               chan_sel   <= exit_sel;
            end else begin
               err_eos <= 1'b1;
            end
         end else if (wr_csel) begin
            chan_sel <= wdata_ch;
         end
      end
   end

endmodule

// File: rtl/chcmd_cmdreg.sv
module chcmd_cmdreg #(
   parameter int TYPE_W     = 4,
   parameter int PARAM_W    = 4,
   parameter int CH_W       = 2,
   parameter int MIN_CMD_CH = 2,
   localparam int DATA_W    = TYPE_W + PARAM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cmd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CH_W-1:0]   sel,
   input  logic              cmd_accept,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_word,
   output logic [CH_W-1:0]   cmd_chan,
   output logic              err_cmd
);

   logic [TYPE_W-1:0] wr_type;
   logic              chan_ok;
   logic              multi;
   logic              legal;

   assign wr_type = wdata[DATA_W-1 -: TYPE_W];
   assign chan_ok = (sel >= CH_W'(MIN_CMD_CH));
   assign multi   = ($countones(wr_type) > 1);
   assign legal   = wr_cmd && chan_ok && !multi && (wr_type != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_word  <= '0;
         cmd_chan  <= '0;
         err_cmd   <= 1'b0;
      end else begin
         err_cmd <= wr_cmd && chan_ok && multi;
         if (cmd_valid) begin
            if (cmd_accept) begin
               cmd_valid <= 1'b0;
               cmd_word  <= '0;
            end
         end else if (legal) begin
            cmd_valid <= 1'b1;
            cmd_word  <= wdata;
            cmd_chan  <= sel;
         end
      end
   end

endmodule

// File: rtl/chcmd_rdmux.sv
module chcmd_rdmux #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int CH_W   = 2,
   parameter int A_CSEL = 0,
   parameter int A_CMD  = 1,
   parameter int A_STAT = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic [CH_W-1:0]   chan_sel,
   input  logic [DATA_W-1:0] cmd_word,
   input  logic [CH_W-1:0]   cmd_chan,
   input  logic              cmd_valid,
   input  logic              svc_active,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (addr == ADDR_W'(A_CSEL)) begin
            rdata[CH_W-1:0] = chan_sel;
         end else if (addr == ADDR_W'(A_CMD)) begin
            if (cmd_chan == chan_sel) rdata = cmd_word;
         end else if (addr == ADDR_W'(A_STAT)) begin
            rdata[1] = cmd_valid;
            rdata[0] = svc_active;
         end
      end
   end

endmodule

// File: rtl/chan_cmd_ctrl.sv
module chan_cmd_ctrl #(
   parameter int NCHAN      = 4,
   parameter int TYPE_W     = 4,
   parameter int PARAM_W    = 4,
   parameter int MIN_CMD_CH = 2,
   parameter int ADDR_W     = 2,
   parameter int A_CSEL     = 0,
   parameter int A_CMD      = 1,
   parameter int A_EOS      = 2,
   parameter int A_STAT     = 3,
   parameter bit RESTORE    = 1'b1,
   localparam int CH_W      = $clog2(NCHAN),
   localparam int DATA_W    = TYPE_W + PARAM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              svc_ack,
   input  logic [CH_W-1:0]   svc_chan,
   output logic              cmd_valid,
   input  logic              cmd_accept,
   output logic [CH_W-1:0]   cmd_chan,
   output logic [TYPE_W-1:0] cmd_type,
   output logic [PARAM_W-1:0] cmd_param,
   output logic [CH_W-1:0]   chan_sel,
   output logic              svc_active,
   output logic              err_cmd,
   output logic              err_eos
);
   import chcmd_pkg::*;

   initial begin
      assert (NCHAN >= 2) else $fatal(1, "NCHAN below 2");
      assert (MIN_CMD_CH < NCHAN) else $fatal(1, "no channel takes commands");
      assert (DATA_W <= 8) else $fatal(1, "command word wider than 8");
      assert ((1 << ADDR_W) > A_STAT) else $fatal(1, "offset out of range");
   end

   wr_dec_t          wr;
   logic [DATA_W-1:0] cmd_word;

   assign wr.csel = bus_wr && (bus_addr == ADDR_W'(A_CSEL));
   assign wr.cmd  = bus_wr && (bus_addr == ADDR_W'(A_CMD));
   assign wr.eos  = bus_wr && (bus_addr == ADDR_W'(A_EOS));

   chcmd_chsel #(.CH_W(CH_W), .RESTORE(RESTORE)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_csel    (wr.csel),
      .wr_eos     (wr.eos),
      .wdata_ch   (bus_wdata[CH_W-1:0]),
      .svc_ack    (svc_ack),
      .svc_chan   (svc_chan),
      .chan_sel   (chan_sel),
      .svc_active (svc_active),
      .err_eos    (err_eos)
   );

   chcmd_cmdreg #(
      .TYPE_W(TYPE_W), .PARAM_W(PARAM_W), .CH_W(CH_W), .MIN_CMD_CH(MIN_CMD_CH)
   ) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cmd     (wr.cmd),
      .wdata      (bus_wdata),
      .sel        (chan_sel),
      .cmd_accept (cmd_accept),
      .cmd_valid  (cmd_valid),
      .cmd_word   (cmd_word),
      .cmd_chan   (cmd_chan),
      .err_cmd    (err_cmd)
   );

   assign cmd_type  = cmd_word[DATA_W-1 -: TYPE_W];
   assign cmd_param = cmd_word[PARAM_W-1:0];

   chcmd_rdmux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W),
      .A_CSEL(A_CSEL), .A_CMD(A_CMD), .A_STAT(A_STAT)
   ) u_rd (
      .addr       (bus_addr),
      .rd         (bus_rd),
      .chan_sel   (chan_sel),
      .cmd_word   (cmd_word),
      .cmd_chan   (cmd_chan),
      .cmd_valid  (cmd_valid),
      .svc_active (svc_active),
      .rdata      (bus_rdata)
   );

endmodule

// File: rtl/chcmd_chk.sv
module chcmd_chk #(
   parameter int CH_W       = 2,
   parameter int TYPE_W     = 4,
   parameter int PARAM_W    = 4,
   parameter int ADDR_W     = 2,
   parameter int MIN_CMD_CH = 2,
   parameter int A_EOS      = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              svc_ack,
   input logic [CH_W-1:0]   svc_chan,
   input logic              cmd_valid,
   input logic              cmd_accept,
   input logic [CH_W-1:0]   cmd_chan,
   input logic [TYPE_W-1:0] cmd_type,
   input logic [PARAM_W-1:0] cmd_param,
   input logic [CH_W-1:0]   chan_sel,
   input logic              svc_active,
   input logic              err_eos
);

   logic eos_wr;
   assign eos_wr = bus_wr && (bus_addr == ADDR_W'(A_EOS));

   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_accept |=> cmd_valid && $stable(cmd_type)
                                   && $stable(cmd_param) && $stable(cmd_chan));

   p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_accept |=> !cmd_valid);

   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (cmd_type == '0) && (cmd_param == '0));

   p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $countones(cmd_type) == 1);

   p_upper_chan_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> cmd_chan >= CH_W'(MIN_CMD_CH));

   p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      svc_ack && !svc_active |=> svc_active && chan_sel == $past(svc_chan));

   p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eos_wr && svc_active |=> !svc_active);

   p_stray_eos_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eos_wr && !svc_active && !svc_ack |=> err_eos && !svc_active);

endmodule

bind chan_cmd_ctrl chcmd_chk #(
   .CH_W(CH_W), .TYPE_W(TYPE_W), .PARAM_W(PARAM_W), .ADDR_W(ADDR_W),
   .MIN_CMD_CH(MIN_CMD_CH), .A_EOS(A_EOS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .svc_ack(svc_ack), .svc_chan(svc_chan), .cmd_valid(cmd_valid),
   .cmd_accept(cmd_accept), .cmd_chan(cmd_chan), .cmd_type(cmd_type),
   .cmd_param(cmd_param), .chan_sel(chan_sel), .svc_active(svc_active),
   .err_eos(err_eos)
);

// File: tb/test_chan_cmd_ctrl.sv
module test_chan_cmd_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       svc_ack = 1'b0;
   logic [1:0] svc_chan = '0;
   logic       cmd_valid;
   logic       cmd_accept = 1'b0;
   logic [1:0] cmd_chan;
   logic [3:0] cmd_type;
   logic [3:0] cmd_param;
   logic [1:0] chan_sel;
   logic       svc_active;
   logic       err_cmd;
   logic       err_eos;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the requirements
   logic [1:0] m_sel, m_sav, m_cch;
   logic       m_act, m_val, m_errc, m_erre;
   logic [7:0] m_creg;

   always #5 clk = ~clk;

   chan_cmd_ctrl i_chan_cmd_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .svc_ack(svc_ack), .svc_chan(svc_chan), .cmd_valid(cmd_valid),
      .cmd_accept(cmd_accept), .cmd_chan(cmd_chan), .cmd_type(cmd_type),
      .cmd_param(cmd_param), .chan_sel(chan_sel), .svc_active(svc_active),
      .err_cmd(err_cmd), .err_eos(err_eos)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0: return {6'b0, m_sel};
         2'd1: return (m_cch == m_sel) ? m_creg : 8'h00;
         2'd3: return {6'b0, m_val, m_act};
         default: return 8'h00;
      endcase
   endfunction

   // op: 0 write, 1 read, 2 service ack, 3 accept, 4 idle
   task automatic model_apply(input int op, input logic [1:0] a, input logic [7:0] d,
                              input logic [1:0] sc);
      logic pre_val;
      pre_val = m_val;
      m_errc = 1'b0;
      m_erre = 1'b0;
      if (op == 3 && m_val) begin
         m_val  = 1'b0;
         m_creg = 8'h00;
      end
      if (op == 0) begin
         if (a == 2'd0) m_sel = d[1:0];
         else if (a == 2'd1 && m_sel >= 2'd2) begin
            if ($countones(d[7:4]) > 1) m_errc = 1'b1;
            else if (!pre_val && d[7:4] != 4'h0) begin
               m_creg = d;
               m_cch  = m_sel;
               m_val  = 1'b1;
            end
         end else if (a == 2'd2) begin
            if (m_act) begin
               m_sel = m_sav;
               m_act = 1'b0;
            end else m_erre = 1'b1;
         end
      end
      if (op == 2 && !m_act) begin
         m_sav = m_sel;
         m_sel = sc;
         m_act = 1'b1;
      end
   endtask

   task automatic compare_all(input string req);
      check({req, " chan_sel"},   32'(chan_sel),   32'(m_sel));
      check({req, " svc_active"}, 32'(svc_active), 32'(m_act));
      check({req, " cmd_valid"},  32'(cmd_valid),  32'(m_val));
      check({req, " cmd_word"},   32'({cmd_type, cmd_param}), 32'(m_creg));
      if (m_val) check({req, " cmd_chan"}, 32'(cmd_chan), 32'(m_cch));
      check({req, " err_cmd"},    32'(err_cmd),    32'(m_errc));
      check({req, " err_eos"},    32'(err_eos),    32'(m_erre));
   endtask

   task automatic step(input string req, input int op, input logic [1:0] a,
                       input logic [7:0] d, input logic [1:0] sc);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = (op == 0);
      bus_rd    = (op == 1);
      svc_ack   = (op == 2);
      svc_chan  = sc;
      cmd_accept = (op == 3);
      if (op == 1) begin
         #1;
         check({req, " read"}, 32'(bus_rdata), 32'(exp_read(a)));
      end
      @(negedge clk);
      bus_wr = 1'b0;
      bus_rd = 1'b0;
      svc_ack = 1'b0;
      cmd_accept = 1'b0;
      model_apply(op, a, d, sc);
      compare_all(req);
   endtask

   initial begin
      #(64'd200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_sel = 0; m_sav = 0; m_cch = 0; m_act = 0; m_val = 0;
      m_errc = 0; m_erre = 0; m_creg = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_all("R1 reset");
      step("R1 reset read", 1, 2'd0, 8'h00, 2'd0);

      // R2 select write and readback
      step("R2 write", 0, 2'd0, 8'hFF, 2'd0);
      step("R2 read", 1, 2'd0, 8'h00, 2'd0);

      // R3 legal command on channel 3
      step("R3 cmd", 0, 2'd1, 8'h25, 2'd0);
      check("R3 type", 32'(cmd_type), 32'h2);
      step("R7 status busy", 1, 2'd3, 8'h00, 2'd0);
      step("R7 write while busy", 0, 2'd1, 8'h41, 2'd0);
      step("R11 readback own chan", 1, 2'd1, 8'h00, 2'd0);
      step("R11 select 2", 0, 2'd0, 8'h02, 2'd0);
      step("R11 readback other chan", 1, 2'd1, 8'h00, 2'd0);
      step("R11 select 3", 0, 2'd0, 8'h03, 2'd0);

      // R4 hold then accept
      step("R4 hold", 4, 2'd0, 8'h00, 2'd0);
      step("R4 hold", 4, 2'd0, 8'h00, 2'd0);
      step("R4 accept", 3, 2'd0, 8'h00, 2'd0);
      check("R4 cleared", 32'(cmd_valid), 32'h0);
      step("R4 readback zero", 1, 2'd1, 8'h00, 2'd0);
      step("R7 status idle", 1, 2'd3, 8'h00, 2'd0);

      // R5 lower channels ignore commands
      step("R5 sel1", 0, 2'd0, 8'h01, 2'd0);
      step("R5 cmd ch1", 0, 2'd1, 8'h12, 2'd0);
      step("R5 readback", 1, 2'd1, 8'h00, 2'd0);
      step("R5 sel0", 0, 2'd0, 8'h00, 2'd0);
      step("R5 cmd ch0 multi", 0, 2'd1, 8'hF3, 2'd0);

      // R6 multi-type and zero-type words
      step("R6 sel2", 0, 2'd0, 8'h02, 2'd0);
      step("R6 multi", 0, 2'd1, 8'h33, 2'd0);
      check("R6 err pulse", 32'(err_cmd), 32'h1);
      step("R6 pulse ends", 4, 2'd0, 8'h00, 2'd0);
      step("R6 zero type", 0, 2'd1, 8'h07, 2'd0);

      // R8 service entry, R9 exit with restore
      step("R8 enter", 2, 2'd0, 8'h00, 2'd1);
      check("R8 sel", 32'(chan_sel), 32'h1);
      step("R8 status", 1, 2'd3, 8'h00, 2'd0);
      step("R8 ack while active", 2, 2'd0, 8'h00, 2'd3);
      step("R9 eos", 0, 2'd2, 8'hA5, 2'd0);
      check("R9 restored", 32'(chan_sel), 32'h2);

      // R10 stray end-of-service, R11 write-only location
      step("R10 stray eos", 0, 2'd2, 8'h5A, 2'd0);
      check("R10 err pulse", 32'(err_eos), 32'h1);
      step("R11 eos read", 1, 2'd2, 8'h00, 2'd0);

      // constrained random phase
      void'($urandom(32'h5EED_1284));
      for (int i = 0; i < 3000; i++) begin
         int op;
         logic [1:0] a;
         logic [7:0] d;
         int k;
         op = int'($urandom % 5);
         a  = 2'($urandom % 4);
         k  = int'($urandom % 4);
         d  = 8'($urandom);
         if (k != 1) d[7:4] = 4'(1 << ($urandom % 4));
         if (op == 0 && a == 2'd3) a = 2'd1;
         step("R3/R4/R6/R8/R9 random", op, a, d, 2'($urandom % 4));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule